// File: doc/BRIEF.md
# Parallel SDI Scrambler with NRZI Encoder

This block sits in front of a 10-bit serializer. Each clock it takes one parallel video character and returns one encoded character. The encoding is a self-synchronizing scrambler with polynomial x^9 + x^4 + 1, followed by NRZ-to-NRZI conversion. All ten serial bit positions are advanced inside a single clock, least significant bit first. The scrambler and NRZI state carry over from one word to the next, so the serializer sees one continuous scrambled line stream.

The front end can fold 8-bit sources into the 10-bit code space. It also tracks the timing reference preamble and can replace reserved code values that fall outside a preamble. A bypass input sends the raw input characters straight to the output for non-compliant streams or diagnostics. Latency is one clock in every mode.

Top module: `sdi_scrambler_top`

## Requirements
- R1: While rst_ni is low, data_o, trs_det_o and valid_o are 0, and the scrambler and NRZI state are cleared to zero.
- R2: valid_o goes high at the first rising clock edge after reset is released and then stays high.
- R3: The output for the input sampled at one rising edge appears right after that edge. The latency is one clock in both normal and bypass mode.
- R4: Word bits are scrambled in order from bit 0 to bit 9. Each scrambled bit equals the input bit XOR the scrambled bits produced 4 and 9 bit positions earlier. This history carries across word boundaries.
- R5: Each output bit equals the previous output bit XOR the current scrambled bit. For bit 0, the previous output bit is bit 9 of the previous encoded word.
- R6: With bypass_i high, data_o is the raw data_i of the previous clock. Scrambler and NRZI state hold during bypass, so normal encoding resumes exactly where it stopped.
- R7: With mode8_i high, the working word is {data_i[9:2], 2'b00}, and data_i[1:0] is ignored. If data_i[9:2] is 8'hFF, the working word is 10'h3FF.
- R8: trs_det_o is high for one clock, aligned with the output of the last word of a working-word sequence 3FF, 000, 000. Any 3FF restarts the sequence. Detection runs in bypass mode too.
- R9: With filt_en_i high and bypass low, working words 001 to 003 are encoded as 004, and working words 3FC to 3FE are encoded as 3FB.
- R10: With filtering on, 3FF is always kept. A 000 is kept only as the second or third word of a preamble and is otherwise encoded as 004. With filtering off, no word is altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 10 | Input character |
| bypass_i | input | 1 | Raw pass-through, no scrambling or NRZI |
| filt_en_i | input | 1 | Enables reserved-code filtering |
| mode8_i | input | 1 | Input is 8-bit, left-aligned |
| data_o | output | 10 | Encoded character for the serializer |
| trs_det_o | output | 1 | Preamble completed on this output word |
| valid_o | output | 1 | Output is meaningful since reset release |

## Verification
The bench runs long word streams so that state which fails to carry over a word boundary shows up. A design that restarts the scrambler per word, or that takes the NRZI seed from the wrong bit, diverges from the second word onward. Bypass is sandwiched between normal stretches: a design that advances its state during bypass produces wrong codes after resume, and a design that adds a stage in one path shows a shifted word.

Preamble cases include a doubled 3FF, a broken 000 run and 8-bit FF/00 forms. Wrong tracking either misses the detect or fires it twice. Filter cases hit every reserved value and a stray 000. A design that filters preamble words, or filters with filtering off, sends altered codes.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int WORD_W  = 10;
  localparam int SCR_LEN = 9;
  localparam int SCR_TAP = 4;
  localparam int RSV_N   = 4;

  typedef enum logic [1:0] {
    TRS_IDLE = 2'd0,
    TRS_ONE  = 2'd1,
    TRS_TWO  = 2'd2
  } trs_st_e;
endpackage

// File: rtl/sdi_trs_filter.sv
module sdi_trs_filter
  import sdi_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = RSV_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         mode8_i,
  input  logic         filt_en_i,
  output logic [W-1:0] word_o,
  output logic         trs_o
);
  localparam logic [W-1:0] ALL1    = '1;
  localparam logic [W-1:0] ALL0    = '0;
  localparam logic [W-1:0] LO_SAFE = W'(N);
  localparam logic [W-1:0] HI_SAFE = ALL1 - W'(N);

  logic [W-1:0] norm;
  logic         is_hi, is_lo, in_pre;
  trs_st_e      st_q, st_d;

  always_comb begin
    norm = data_i;
    if (mode8_i) begin
      norm = {data_i[W-1:2], 2'b00};
      if (&data_i[W-1:2]) norm = ALL1;
    end
  end

  assign is_hi  = (norm == ALL1);
  assign is_lo  = (norm == ALL0);
  assign in_pre = is_hi || (is_lo && st_q != TRS_IDLE);
  assign trs_o  = is_lo && (st_q == TRS_TWO);

  always_comb begin
    if (is_hi)                         st_d = TRS_ONE;
    else if (is_lo && st_q == TRS_ONE) st_d = TRS_TWO;
    else                               st_d = TRS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TRS_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    word_o = norm;
    if (filt_en_i && !in_pre) begin
      if (norm < LO_SAFE)      word_o = LO_SAFE;
      else if (norm > HI_SAFE) word_o = HI_SAFE;
    end
  end

  // R9
  filt_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_en_i |-> !(word_o > HI_SAFE && word_o != ALL1));
  // R10
  filt_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && word_o < LO_SAFE) |-> (word_o == ALL0 && st_q != TRS_IDLE));
endmodule

// File: rtl/sdi_scram_core.sv
module sdi_scram_core
  import sdi_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int LEN = SCR_LEN,
  parameter int TAP = SCR_TAP
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] enc_o
);
  logic [LEN-1:0] scr_q, scr_d;
  logic           nrzi_q, nrzi_d;

  // sr[k] holds the scrambled bit k+1 positions back
  always_comb begin
    logic [LEN-1:0] sr;
    logic           nz, s;
    sr = scr_q;
    nz = nrzi_q;
    for (int i = 0; i < W; i++) begin
      s        = word_i[i] ^ sr[TAP-1] ^ sr[LEN-1];
      sr       = {sr[LEN-2:0], s};
      nz       = nz ^ s;
      enc_o[i] = nz;
    end
    scr_d  = sr;
    nrzi_d = nz;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scr_q  <= '0;
      nrzi_q <= 1'b0;
    end else if (adv_i) begin
      scr_q  <= scr_d;
      nrzi_q <= nrzi_d;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(scr_q) && $stable(nrzi_q)));
endmodule

// File: rtl/sdi_scrambler_top.sv
module sdi_scrambler_top
  import sdi_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         bypass_i,
  input  logic         filt_en_i,
  input  logic         mode8_i,
  output logic [W-1:0] data_o,
  output logic         trs_det_o,
  output logic         valid_o
);
  logic [W-1:0] word, enc;
  logic         trs;

  sdi_trs_filter #(.W(W)) i_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .mode8_i   (mode8_i),
    .filt_en_i (filt_en_i),
    .word_o    (word),
    .trs_o     (trs)
  );

  sdi_scram_core #(.W(W)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (!bypass_i),
    .word_i (word),
    .enc_o  (enc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      trs_det_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      data_o    <= bypass_i ? data_i : enc;
      trs_det_o <= trs;
      valid_o   <= 1'b1;
    end
  end

  // R6
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (data_o == $past(data_i)));
  // R2
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R8
  trs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trs_det_o |=> !trs_det_o);
endmodule

// File: tb/test_sdi_scrambler_top.sv
module test_sdi_scrambler_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       byp = 1'b0, filt = 1'b0, m8 = 1'b0;
  logic [9:0] dout;
  logic       trs, vld;

  int n_chk = 0, n_bad = 0;

  logic [8:0] m_scr = '0;
  logic       m_nz = 1'b0;
  int         m_seq = 0;

  always #5 clk = ~clk;

  sdi_scrambler_top i_sdi_scrambler_top (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .bypass_i(byp),
    .filt_en_i(filt), .mode8_i(m8), .data_o(dout), .trs_det_o(trs), .valid_o(vld)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_scr = '0; m_nz = 1'b0; m_seq = 0;
  endtask

  // Drive one word, compute expectation from the requirements, check after the edge.
  task automatic push(input string tag, input logic [9:0] d);
    logic [9:0] w, e;
    logic       et, s, pre;
    w = d;
    if (m8) begin
      w = {d[9:2], 2'b00};
      if (d[9:2] == 8'hFF) w = 10'h3FF;
    end
    pre = (w == 10'h3FF) || (w == 10'h000 && m_seq != 0);
    et  = (w == 10'h000 && m_seq == 2);
    if (w == 10'h3FF) m_seq = 1;
    else if (w == 10'h000 && m_seq == 1) m_seq = 2;
    else m_seq = 0;
    if (filt && !pre) begin
      if (w < 10'h004) w = 10'h004;
      else if (w > 10'h3FB) w = 10'h3FB;
    end
    if (byp) e = d;
    else begin
      for (int i = 0; i < 10; i++) begin
        s = w[i] ^ m_scr[3] ^ m_scr[8];
        m_scr = {m_scr[7:0], s};
        m_nz = m_nz ^ s;
        e[i] = m_nz;
      end
    end
    din = d;
    @(posedge clk); #2;
    chk({tag, " data"}, dout, e);
    chk({tag, " trs"}, {9'b0, trs}, {9'b0, et});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; din = 10'h2A5; byp = 1'b0;
    @(posedge clk); #2;
    chk("R1 data", dout, '0);
    chk("R1 trs", {9'b0, trs}, '0);
    chk("R1 valid", {9'b0, vld}, '0);
    model_reset();
    din = '0; rst_n = 1'b1;
    chk("R2 valid before edge", {9'b0, vld}, '0);
    push("R2", 10'h000);
    chk("R2 valid", {9'b0, vld}, 10'd1);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 4; i++) push("R4 zero stream", 10'h000);
  endtask

  task automatic t_scramble();
    push("R4 first", 10'h001);
    push("R5 ones", 10'h3FE);
    push("R4", 10'h155);
    push("R5", 10'h2AA);
    for (int i = 0; i < 24; i++) push("R3 R4 R5 stream", 10'((i * 37 + 11) & 10'h3FF) | 10'h010);
  endtask

  task automatic t_bypass();
    byp = 1'b1;
    push("R6 raw", 10'h123);
    push("R6 raw", 10'h3FC);
    push("R6 raw", 10'h001);
    byp = 1'b0;
    push("R6 R3 resume", 10'h0F0);
    push("R6 resume", 10'h20F);
    byp = 1'b1;
    push("R3 bypass", 10'h111);
    byp = 1'b0;
  endtask

  task automatic t_mode8();
    m8 = 1'b1;
    push("R7", 10'h0A3);
    push("R7 low bits", 10'h0A0);
    push("R7 FF", 10'h3FD);
    push("R7 00", 10'h002);
    push("R8 R7 00", 10'h001);
    m8 = 1'b0;
  endtask

  task automatic t_trs();
    push("R8", 10'h3FF); push("R8", 10'h000); push("R8 detect", 10'h000);
    push("R8 after", 10'h200);
    push("R8 double", 10'h3FF); push("R8 double", 10'h3FF);
    push("R8 double", 10'h000); push("R8 double", 10'h000);
    push("R8 broken", 10'h3FF); push("R8 broken", 10'h000); push("R8 broken", 10'h001);
    byp = 1'b1;
    push("R8 bypass", 10'h3FF); push("R8 bypass", 10'h000); push("R8 bypass", 10'h000);
    byp = 1'b0;
  endtask

  task automatic t_filter();
    filt = 1'b1;
    push("R9 low", 10'h001); push("R9 low", 10'h002); push("R9 low", 10'h003);
    push("R9 high", 10'h3FC); push("R9 high", 10'h3FD); push("R9 high", 10'h3FE);
    push("R9 edge", 10'h004); push("R9 edge", 10'h3FB);
    push("R10 stray 000", 10'h000);
    push("R10 pre", 10'h3FF); push("R10 pre", 10'h000); push("R10 pre", 10'h000);
    push("R10 third 000", 10'h000);
    filt = 1'b0;
    push("R10 off", 10'h001); push("R10 off", 10'h3FE); push("R10 off", 10'h000);
  endtask

  task automatic t_midreset();
    rst_n = 1'b0;
    #1;
    chk("R1 async", dout, '0);
    @(posedge clk); #2;
    model_reset();
    rst_n = 1'b1;
    push("R1 restart", 10'h155);
    push("R1 restart", 10'h0C3);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_zero();
    t_scramble();
    t_bypass();
    t_mode8();
    t_trs();
    t_filter();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule